// File: doc/BRIEF.md
# Pipeline Interlock and Bypass Controller

This block decides, every cycle, whether an in-order integer pipeline with five stages (fetch, decode, execute, memory, writeback) may advance. It compares the source registers of the instruction in decode against the destinations of the older instructions in execute and memory. From that comparison it raises a stall on fetch and decode and puts a bubble into execute. When a taken branch reaches the memory stage, it raises flush signals for the three younger stages. It also produces the operand bypass selects that the execute stage uses one cycle later.

A static mode input selects between two configurations. With bypassing off, a consumer waits in decode until its producer has reached writeback. The register file writes in the first half of the cycle and reads in the second half, so a producer in writeback is already visible. With bypassing on, ALU results are picked up from the execute/memory or memory/writeback latches with no wait. Only a load followed at once by a consumer of its result costs a single cycle. Branches are predicted not taken and resolve in the memory stage.

Top module: `hazard_ctrl`

## Requirements
- R1: A source or destination field equal to register 0 never causes a stall and never selects a bypass path.
- R2: With `fwd_en`=0, a decode source matching the destination of a writing instruction in execute or memory raises `stall_if`, `stall_id` and `bubble_ex` in that same cycle. A producer that has already reached writeback causes no stall.
- R3: With `fwd_en`=1, a producer that is not a load never stalls. On the next clock edge each select becomes 2 (execute/memory latch) if the matching producer was in execute, otherwise 1 (memory/writeback latch) if it was in memory, otherwise 0 (register file). The execute-stage producer wins when both match.
- R4: With `fwd_en`=1, a load in execute whose destination matches a decode source stalls for exactly that cycle. Once the load is in memory, the consumer receives select 1.
- R5: `br_taken` raises `flush_if`, `flush_id` and `flush_ex` in the same cycle and forces the stall outputs and `bubble_ex` low, even when a dependence exists.
- R6: Both selects read 0 after any cycle in which bypassing was off, a stall was raised, or a flush was raised.
- R7: A synchronous reset clears both selects.
- R8: When the controller drives a pipeline running the six-instruction loop (load, increment, store, pointer step, counter step, branch-if-nonzero) for 99 passes, the last branch leaves writeback in cycle 1486 with bypassing off and in cycle 991 with it on. The first load is fetched in cycle 1.
- R9: A producer whose write enable is low causes neither a stall nor a bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | 1 = full bypassing, 0 = no bypassing |
| id_rs1 | input | REG_AW | First source register of the decode instruction (0 if unused) |
| id_rs2 | input | REG_AW | Second source register of the decode instruction (0 if unused) |
| ex_rd | input | REG_AW | Destination of the execute instruction |
| ex_we | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | REG_AW | Destination of the memory instruction |
| mem_we | input | 1 | Memory instruction writes a register |
| br_taken | input | 1 | Branch in memory stage resolved taken |
| stall_if | output | 1 | Hold the fetch stage |
| stall_id | output | 1 | Hold the decode stage |
| bubble_ex | output | 1 | Load a bubble into execute |
| flush_if | output | 1 | Squash the fetched instruction |
| flush_id | output | 1 | Squash the decode instruction |
| flush_ex | output | 1 | Squash the execute instruction |
| fwd_a | output | 2 | Operand A bypass select for the execute stage |
| fwd_b | output | 2 | Operand B bypass select for the execute stage |

## Verification
The stall, bubble and flush outputs are combinational, so the bench drives each stimulus after a falling edge and checks them 1 ns later, within the same cycle. The bypass selects go through one register, so the bench checks them at the falling edge after the next rising edge. That is the cycle in which the decode instruction sits in execute. The loop test closes the controller's outputs around a small pipeline model in the bench. It counts cycles from the first fetch to the cycle in which the final branch occupies writeback, and compares that count with the figures in R8.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int NSRC = 2;
  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_WB  = 2'd1,
    FWD_EXM = 2'd2
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  output logic              hit_ex,
  output logic              hit_mem
);
  logic src_live;
  // register 0 is hardwired, never a real dependence
  assign src_live = (src != '0);
  assign hit_ex   = src_live && ex_we  && (ex_rd  == src);
  assign hit_mem  = src_live && mem_we && (mem_rd == src);
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int NSRC = 2
) (
  input  logic            fwd_en,
  input  logic [NSRC-1:0] hit_ex,
  input  logic [NSRC-1:0] hit_mem,
  input  logic            ex_load,
  input  logic            br_taken,
  output logic            stall,
  output logic            flush
);
  logic dep_plain, dep_load, need_stall;

  always_comb begin
    dep_plain  = (|hit_ex) || (|hit_mem);
    dep_load   = ex_load && (|hit_ex);
    need_stall = fwd_en ? dep_load : dep_plain;
    // a taken branch squashes the consumer, so its stall is moot
    flush      = br_taken;
    stall      = need_stall && !br_taken;
  end
endmodule

// File: rtl/hz_fwd_reg.sv
module hz_fwd_reg
  import hz_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fwd_en,
  input  logic                 kill,
  input  logic [NSRC-1:0]      hit_ex,
  input  logic [NSRC-1:0]      hit_mem,
  output logic [NSRC-1:0][1:0] sel
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    fwd_sel_e nxt;
    always_comb begin
      if (!fwd_en || kill)  nxt = FWD_RF;
      else if (hit_ex[g])   nxt = FWD_EXM;
      else if (hit_mem[g])  nxt = FWD_WB;
      else                  nxt = FWD_RF;
    end
    always_ff @(posedge clk) begin
      if (rst) sel[g] <= FWD_RF;
      else     sel[g] <= nxt;
    end
  end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwd_en,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic              br_taken,
  output logic              stall_if,
  output logic              stall_id,
  output logic              bubble_ex,
  output logic              flush_if,
  output logic              flush_id,
  output logic              flush_ex,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b
);
  logic [NSRC-1:0][REG_AW-1:0] srcs;
  logic [NSRC-1:0]             hit_ex, hit_mem;
  logic [NSRC-1:0][1:0]        sel;
  logic                        stall, flush;

  assign srcs[0] = id_rs1;
  assign srcs[1] = id_rs2;

  for (genvar g = 0; g < NSRC; g++) begin : g_match
    hz_src_match #(.REG_AW(REG_AW)) u_match (
      .src    (srcs[g]),
      .ex_rd  (ex_rd),
      .ex_we  (ex_we),
      .mem_rd (mem_rd),
      .mem_we (mem_we),
      .hit_ex (hit_ex[g]),
      .hit_mem(hit_mem[g])
    );
  end

  hz_interlock #(.NSRC(NSRC)) u_lock (
    .fwd_en  (fwd_en),
    .hit_ex  (hit_ex),
    .hit_mem (hit_mem),
    .ex_load (ex_load),
    .br_taken(br_taken),
    .stall   (stall),
    .flush   (flush)
  );

  hz_fwd_reg #(.NSRC(NSRC)) u_fwd (
    .clk    (clk),
    .rst    (rst),
    .fwd_en (fwd_en),
    .kill   (stall || flush),
    .hit_ex (hit_ex),
    .hit_mem(hit_mem),
    .sel    (sel)
  );

  assign stall_if  = stall;
  assign stall_id  = stall;
  assign bubble_ex = stall;
  assign flush_if  = flush;
  assign flush_id  = flush;
  assign flush_ex  = flush;
  assign fwd_a     = sel[0];
  assign fwd_b     = sel[1];
endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              fwd_en,
  input logic [REG_AW-1:0] id_rs1,
  input logic [REG_AW-1:0] id_rs2,
  input logic              ex_load,
  input logic              br_taken,
  input logic              stall_if,
  input logic              stall_id,
  input logic              bubble_ex,
  input logic              flush_if,
  input logic              flush_id,
  input logic              flush_ex,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b
);
  a_r5_flush_wins: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (flush_if && flush_id && flush_ex && !stall_if && !stall_id && !bubble_ex));

  a_r6_nofwd_sel: assert property (@(posedge clk) disable iff (rst)
    !fwd_en |=> (fwd_a == 2'd0 && fwd_b == 2'd0));

  a_r6_kill_sel: assert property (@(posedge clk) disable iff (rst)
    (stall_id || flush_id) |=> (fwd_a == 2'd0 && fwd_b == 2'd0));

  a_r1_zero_src: assert property (@(posedge clk) disable iff (rst)
    (id_rs1 == '0 && id_rs2 == '0) |-> !stall_id);

  a_r3_alu_nostall: assert property (@(posedge clk) disable iff (rst)
    (fwd_en && !ex_load) |-> !stall_id);
endmodule

bind hazard_ctrl hazard_ctrl_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst(rst), .fwd_en(fwd_en), .id_rs1(id_rs1), .id_rs2(id_rs2),
  .ex_load(ex_load), .br_taken(br_taken), .stall_if(stall_if),
  .stall_id(stall_id), .bubble_ex(bubble_ex), .flush_if(flush_if),
  .flush_id(flush_id), .flush_ex(flush_ex), .fwd_a(fwd_a), .fwd_b(fwd_b)
);

// File: tb/tb_hazard_ctrl.sv
`timescale 1ns/1ps
module tb_hazard_ctrl;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst;
  logic fwd_en;
  logic [AW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
  logic ex_we, ex_load, mem_we, br_taken;
  logic stall_if, stall_id, bubble_ex, flush_if, flush_id, flush_ex;
  logic [1:0] fwd_a, fwd_b;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  hazard_ctrl #(.REG_AW(AW)) dut (
    .clk(clk), .rst(rst), .fwd_en(fwd_en), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load), .mem_rd(mem_rd),
    .mem_we(mem_we), .br_taken(br_taken), .stall_if(stall_if),
    .stall_id(stall_id), .bubble_ex(bubble_ex), .flush_if(flush_if),
    .flush_id(flush_id), .flush_ex(flush_ex), .fwd_a(fwd_a), .fwd_b(fwd_b)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // stimulus / expectation vectors
  typedef struct packed {
    logic          fwd;
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
    logic [AW-1:0] exrd;
    logic          exwe;
    logic          exld;
    logic [AW-1:0] memrd;
    logic          memwe;
    logic          tkn;
    logic          xs;
    logic          xf;
    logic [1:0]    xa;
    logic [1:0]    xb;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // fwd rs1 rs2 exrd we ld memrd we tkn | stall flush a b
    '{1'b0, 5'd1,  5'd0,  5'd1,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0}, // R2 ex
    '{1'b0, 5'd0,  5'd3,  5'd0,  1'b0, 1'b0, 5'd3,  1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0}, // R2 mem
    '{1'b0, 5'd4,  5'd0,  5'd9,  1'b1, 1'b0, 5'd8,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R2 no match
    '{1'b0, 5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R1
    '{1'b0, 5'd5,  5'd0,  5'd5,  1'b0, 1'b0, 5'd5,  1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R9
    '{1'b1, 5'd6,  5'd0,  5'd6,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0}, // R3 ex
    '{1'b1, 5'd0,  5'd7,  5'd0,  1'b0, 1'b0, 5'd7,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1}, // R3 mem
    '{1'b1, 5'd8,  5'd8,  5'd8,  1'b1, 1'b0, 5'd8,  1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd2}, // R3 priority
    '{1'b1, 5'd9,  5'd9,  5'd2,  1'b1, 1'b0, 5'd3,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R3 none
    '{1'b1, 5'd10, 5'd0,  5'd10, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0}, // R4 stall
    '{1'b1, 5'd0,  5'd11, 5'd0,  1'b0, 1'b0, 5'd11, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1}, // R4 after
    '{1'b1, 5'd0,  5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}, // R1 fwd
    '{1'b1, 5'd12, 5'd0,  5'd12, 1'b1, 1'b1, 5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0}, // R5 fwd
    '{1'b0, 5'd13, 5'd0,  5'd13, 1'b1, 1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0}, // R5 nofwd
    '{1'b1, 5'd14, 5'd14, 5'd14, 1'b0, 1'b0, 5'd14, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0}  // R9 fwd
  };

  // loop program model: op 0..5 = loop body, 6 = empty slot
  typedef struct packed {
    logic [AW-1:0] rd;
    logic          we;
    logic          ld;
    logic [AW-1:0] rs1;
    logic [AW-1:0] rs2;
  } dec_t;

  function automatic dec_t decode(input int op, input bit v);
    dec_t d = '0;
    if (v) begin
      case (op)
        0: begin d.rd = 5'd1; d.we = 1'b1; d.ld = 1'b1; d.rs1 = 5'd2; end // load r1,(r2)
        1: begin d.rd = 5'd1; d.we = 1'b1; d.rs1 = 5'd1; end               // r1 += 1
        2: begin d.rs1 = 5'd2; d.rs2 = 5'd1; end                            // store r1,(r2)
        3: begin d.rd = 5'd2; d.we = 1'b1; d.rs1 = 5'd2; end               // r2 += 4
        4: begin d.rd = 5'd4; d.we = 1'b1; d.rs1 = 5'd4; end               // r4 -= 4
        5: begin d.rs1 = 5'd4; end                                          // branch r4 != 0
        default: ;
      endcase
    end
    return d;
  endfunction

  task automatic run_loop(input bit fwd, output int cycles);
    bit v  [5];
    int op [5];
    int it [5];
    bit taken;
    dec_t did, dex, dmem;
    cycles = -1;
    for (int s = 0; s < 5; s++) begin v[s] = 1'b0; op[s] = 6; it[s] = 0; end
    v[0] = 1'b1; op[0] = 0; it[0] = 0;
    fwd_en = fwd;
    for (int c = 1; c < 4000; c++) begin
      did  = decode(op[1], v[1]);
      dex  = decode(op[2], v[2]);
      dmem = decode(op[3], v[3]);
      taken    = v[3] && op[3] == 5 && it[3] < 98;
      id_rs1   = did.rs1;  id_rs2 = did.rs2;
      ex_rd    = dex.rd;   ex_we  = dex.we;  ex_load = dex.ld;
      mem_rd   = dmem.rd;  mem_we = dmem.we;
      br_taken = taken;
      #1;
      if (v[4] && op[4] == 5 && it[4] == 98) begin
        cycles = c;
        break;
      end
      v[4] = v[3]; op[4] = op[3]; it[4] = it[3];
      if (flush_ex) v[3] = 1'b0;
      else begin v[3] = v[2]; op[3] = op[2]; it[3] = it[2]; end
      if (flush_id || bubble_ex) v[2] = 1'b0;
      else begin v[2] = v[1]; op[2] = op[1]; it[2] = it[1]; end
      if (flush_if) v[1] = 1'b0;
      else if (!stall_id) begin v[1] = v[0]; op[1] = op[0]; it[1] = it[0]; end
      if (taken) begin
        v[0] = 1'b1; op[0] = 0; it[0] = it[4] + 1;
      end else if (!stall_if) begin
        if (op[0] < 6) op[0] = op[0] + 1;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle_inputs();
    id_rs1 = '0; id_rs2 = '0; ex_rd = '0; ex_we = 0; ex_load = 0;
    mem_rd = '0; mem_we = 0; br_taken = 0; fwd_en = 0;
  endtask

  initial begin : watchdog
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int cyc;
    idle_inputs();
    rst = 1'b1;
    // R7: a bypass-worthy pattern held during reset must not reach the selects
    fwd_en = 1; id_rs1 = 5'd6; id_rs2 = 5'd6; ex_rd = 5'd6; ex_we = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 fwd_a in reset", fwd_a, 0);
    check("R7 fwd_b in reset", fwd_b, 0);
    idle_inputs();
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      fwd_en = VECS[i].fwd; id_rs1 = VECS[i].rs1; id_rs2 = VECS[i].rs2;
      ex_rd = VECS[i].exrd; ex_we = VECS[i].exwe; ex_load = VECS[i].exld;
      mem_rd = VECS[i].memrd; mem_we = VECS[i].memwe; br_taken = VECS[i].tkn;
      #1;
      check($sformatf("R2/R4/R5 stall vec %0d", i),
            {stall_if, stall_id, bubble_ex}, VECS[i].xs ? 7 : 0);
      check($sformatf("R5 flush vec %0d", i),
            {flush_if, flush_id, flush_ex}, VECS[i].xf ? 7 : 0);
      @(negedge clk);
      check($sformatf("R3/R6 fwd_a vec %0d", i), fwd_a, VECS[i].xa);
      check($sformatf("R3/R6 fwd_b vec %0d", i), fwd_b, VECS[i].xb);
    end

    // R7: synchronous reset clears a live select
    fwd_en = 1; id_rs1 = 5'd3; ex_rd = 5'd3; ex_we = 1; ex_load = 0;
    mem_rd = '0; mem_we = 0; br_taken = 0; id_rs2 = '0;
    @(negedge clk);
    check("R3 select before reset", fwd_a, 2);
    rst = 1'b1;
    @(negedge clk);
    check("R7 select cleared by reset", fwd_a, 0);
    rst = 1'b0;
    idle_inputs();
    @(negedge clk);

    // R8: loop timing in both modes
    run_loop(1'b0, cyc);
    check("R8 loop cycles no bypass", cyc, 1486);
    idle_inputs();
    @(negedge clk);
    run_loop(1'b1, cyc);
    check("R8 loop cycles full bypass", cyc, 991);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule